// File: doc/BRIEF.md
# Multiplexed Bus Memory Target with Burst Tracking

This block sits on a 32-bit shared address/data bus as a memory-mapped target. It watches the cycle frame signal to find the one clock in which a transaction's address and 4-bit command are presented. When the command is a memory read or a memory write, and the address falls inside a fixed window of sixteen 32-bit registers, the block claims the transaction. It then walks through the data phases, stepping one register per completed phase.

The data path is a stream with a two-sided handshake. The host's IRDY# acts as "valid" on writes and as "ready" on reads. The block's TRDY# plays the opposite role. The target never applies back-pressure: once it has claimed a transaction, TRDY# stays low for every data-phase cycle. All stalling comes from the host, which holds IRDY# high for as many cycles as it needs. A phase moves only on a clock where both strobes are low. While the host stalls, the read word and the register index stay frozen.

The host ends a burst by raising FRAME# during the final data phase. The block reports that phase on a flag pin, and it releases its strobes on the clock after the phase completes. Transactions the block does not claim are watched but never answered.

Top module: `pci_tgt_tracker`

## Requirements
- R1: After the asynchronous active-low reset, `trdy_n` and `devsel_n` are high, `ad_oe` and `last_o` are low, and all sixteen registers read as zero.
- R2: An address phase is the cycle in which `frame_n` is sampled low while the block is idle. The block claims it only when all of these hold:
  - the command on `cbe_n` is 4'b0110 (memory read) or 4'b0111 (memory write);
  - `ad_in[31:6]` equals `BASE_ADDR[31:6]`;
  - `ad_in[1:0]` is 2'b00.
  From the next cycle until the final phase completes, `devsel_n` and `trdy_n` are low.
- R3: An unclaimed transaction is ignored: `devsel_n` and `trdy_n` stay high and no register changes. The block treats the bus as busy until it samples a cycle with both `frame_n` and `irdy_n` high.
- R4: A data phase completes only on a clock edge where `irdy_n` and `trdy_n` are both low. Cycles with `irdy_n` high write nothing, leave the register index unchanged, and hold `ad_out` steady.
- R5: On a completed write phase, `cbe_n[i]` low writes byte lane `ad_in[8i+7:8i]` into the current register. `cbe_n[i]` high leaves that byte unchanged. Lane 0 is the least significant byte.
- R6: During a claimed read, `ad_oe` is high and `ad_out` equals the current register in every cycle. Otherwise `ad_oe` is low and `ad_out` is zero.
- R7: The first register of a burst is `ad_in[5:2]` of the address phase. Each completed phase advances the index by one (address + 4), and the index wraps from 15 to 0.
- R8: `last_o` is high exactly in cycles where a claimed transaction is active and `frame_n` is high. After that phase completes, `devsel_n` and `trdy_n` return high on the next cycle, and a new address phase may follow in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 32 | Address/data bus as seen by the target |
| cbe_n | input | 4 | Command during the address phase, active-low byte enables during data phases |
| frame_n | input | 1 | Cycle frame from the host, active low |
| irdy_n | input | 1 | Host ready/valid, active low |
| trdy_n | output | 1 | Target ready/valid, active low |
| devsel_n | output | 1 | Transaction claimed, active low |
| ad_out | output | 32 | Read data, zero when not driving |
| ad_oe | output | 1 | Output enable for `ad_out` |
| last_o | output | 1 | Final data phase of a claimed burst |

## Verification
Directed cases exercise several distinct patterns:
- a 16-word write burst with every lane enabled, read back as a burst, separates indexing errors from storage errors;
- writes with no lanes enabled and with alternating lanes isolate byte-enable handling;
- a burst starting at register 14 tests the index wrap;
- an I/O-style command inside the window and a memory write just past the window test the claim decode, confirmed by later reads of the registers those writes could have touched;
- back-to-back transactions with no idle cycle test the release timing.

Random transactions mix both commands, foreign command codes and addresses, burst lengths and host wait states. They check the read data against a bench model and show whether stalls leak into the data path.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_SKIP = 2'd2
  } tgt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int WIN_LSB  = 6,
  parameter int OFF_W    = 2,
  parameter logic [DATA_W-1:0] BASE_ADDR = 32'h0000_1000
) (
  input  logic [DATA_W-1:WIN_LSB] addr_hi,
  input  logic [OFF_W-1:0]        addr_lo,
  input  logic [3:0]              cmd,
  output logic                    hit,
  output logic                    is_read
);

  logic in_window;
  logic mem_cmd;

  always_comb begin
    in_window = (addr_hi == BASE_ADDR[DATA_W-1:WIN_LSB]) && (addr_lo == '0);
    mem_cmd   = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
    hit       = in_window && mem_cmd;
    is_read   = (cmd == CMD_MEM_RD);
  end

endmodule

// File: rtl/pci_tgt_regbank.sv
module pci_tgt_regbank #(
  parameter int REGS   = 16,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_be_n,
  output logic [DATA_W-1:0] rd_data
);

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [7:0] lane_q [REGS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < REGS; r++) lane_q[r] <= '0;
      end else if (wr_en && !wr_be_n[ln]) begin
        lane_q[idx] <= wr_data[ln*8 +: 8];
      end
    end

    assign rd_data[ln*8 +: 8] = lane_q[idx];
  end

endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
  import pci_tgt_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             addr_hit,
  input  logic             addr_is_read,
  input  logic [IDX_W-1:0] start_idx,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             ad_oe,
  output logic             last_o,
  output logic             wr_en,
  output logic [IDX_W-1:0] idx
);

  tgt_state_e state_q;
  logic       read_q;
  logic       active;
  logic       done;

  always_comb begin
    active   = (state_q == ST_DATA);
    done     = active && !irdy_n;
    devsel_n = !active;
    trdy_n   = !active;
    ad_oe    = active && read_q;
    last_o   = active && frame_n;
    wr_en    = done && !read_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      read_q  <= 1'b0;
      idx     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!frame_n) begin
            if (addr_hit) begin
              state_q <= ST_DATA;
              read_q  <= addr_is_read;
              idx     <= start_idx;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_DATA: begin
          if (done) begin
            idx <= idx + 1'b1;
            if (frame_n) state_q <= ST_IDLE;
          end
        end
        ST_SKIP: begin
          if (frame_n && irdy_n) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pci_tgt_tracker.sv
module pci_tgt_tracker #(
  parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
  parameter int          REGS      = 16,
  parameter int          DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [3:0]        cbe_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  output logic              trdy_n,
  output logic              devsel_n,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              last_o
);

  localparam int LANES   = DATA_W / 8;
  localparam int OFF_W   = $clog2(LANES);
  localparam int IDX_W   = $clog2(REGS);
  localparam int WIN_LSB = IDX_W + OFF_W;

  logic             hit;
  logic             is_read;
  logic             wr_en;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] rd_data;

  pci_tgt_decode #(
    .DATA_W   (DATA_W),
    .WIN_LSB  (WIN_LSB),
    .OFF_W    (OFF_W),
    .BASE_ADDR(BASE_ADDR)
  ) i_decode (
    .addr_hi (ad_in[DATA_W-1:WIN_LSB]),
    .addr_lo (ad_in[OFF_W-1:0]),
    .cmd     (cbe_n),
    .hit     (hit),
    .is_read (is_read)
  );

  pci_tgt_fsm #(.IDX_W(IDX_W)) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_n      (frame_n),
    .irdy_n       (irdy_n),
    .addr_hit     (hit),
    .addr_is_read (is_read),
    .start_idx    (ad_in[WIN_LSB-1:OFF_W]),
    .devsel_n     (devsel_n),
    .trdy_n       (trdy_n),
    .ad_oe        (ad_oe),
    .last_o       (last_o),
    .wr_en        (wr_en),
    .idx          (idx)
  );

  pci_tgt_regbank #(.REGS(REGS), .DATA_W(DATA_W)) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .idx     (idx),
    .wr_data (ad_in),
    .wr_be_n (cbe_n[LANES-1:0]),
    .rd_data (rd_data)
  );

  assign ad_out = ad_oe ? rd_data : '0;

endmodule

// File: rtl/pci_tgt_tracker_chk.sv
module pci_tgt_tracker_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_n,
  input logic              irdy_n,
  input logic              trdy_n,
  input logic              devsel_n,
  input logic [DATA_W-1:0] ad_out,
  input logic              ad_oe,
  input logic              last_o
);

  assert_strobes_paired_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trdy_n == devsel_n);

  assert_claim_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> !$past(frame_n));

  assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n && irdy_n) |=> (!devsel_n && $stable(ad_out)));

  assert_oe_only_claimed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !trdy_n);

  assert_bus_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe |-> (ad_out == '0));

  assert_last_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> (!devsel_n && frame_n));

  assert_release_after_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n && frame_n && !irdy_n) |=> (devsel_n && trdy_n));

endmodule

bind pci_tgt_tracker pci_tgt_tracker_chk #(.DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame_n  (frame_n),
  .irdy_n   (irdy_n),
  .trdy_n   (trdy_n),
  .devsel_n (devsel_n),
  .ad_out   (ad_out),
  .ad_oe    (ad_oe),
  .last_o   (last_o)
);

// File: tb/test_pci_tgt_tracker.sv
module test_pci_tgt_tracker;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE       = 32'h0000_1000;
  localparam logic [3:0]  RD         = 4'b0110;
  localparam logic [3:0]  WR         = 4'b0111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic        trdy_n, devsel_n, ad_oe, last_o;
  logic [31:0] ad_out;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_tgt_tracker i_pci_tgt_tracker (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_n(cbe_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .devsel_n(devsel_n), .ad_out(ad_out), .ad_oe(ad_oe), .last_o(last_o)
  );

  function automatic bit exp_claim(logic [31:0] a, logic [3:0] c);
    return (a[31:6] == BASE[31:6]) && (a[1:0] == 2'b00) && (c == RD || c == WR);
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be_n);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (!be_n[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic txn(logic [31:0] addr, logic [3:0] cmd, int nph, bit waits,
                     bit idle_after, int be_force, string rtag);
    bit claimed = exp_claim(addr, cmd);
    bit rd = (cmd == RD);
    logic [3:0] idx = addr[5:2];
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
    #1 chk(devsel_n === 1'b1, "R8 released at address phase", {31'd0, devsel_n}, 32'd1);
    for (int k = 0; k < nph; k++) begin
      int nw = waits ? int'($urandom % 3) : 0;
      logic [31:0] wd;
      logic [3:0]  be;
      for (int w = 0; w < nw; w++) begin
        @(negedge clk);
        irdy_n = 1'b1; frame_n = 1'b0; ad_in = $urandom; cbe_n = 4'($urandom);
        #1 chk(devsel_n === !claimed, "R2/R3 devsel during wait", {31'd0, devsel_n}, {31'd0, !claimed});
        if (claimed && rd)
          chk(ad_out === model[idx], "R4 stall holds read data", ad_out, model[idx]);
      end
      @(negedge clk);
      wd = $urandom;
      be = (be_force < 0) ? 4'($urandom) : 4'(be_force);
      irdy_n = 1'b0; frame_n = (k == nph - 1); ad_in = wd; cbe_n = rd ? 4'b0000 : be;
      #1;
      chk(trdy_n === !claimed, claimed ? "R2 trdy in claimed phase" : "R3 no trdy when unclaimed",
          {31'd0, trdy_n}, {31'd0, !claimed});
      chk(last_o === (claimed && k == nph - 1), "R8 last flag",
          {31'd0, last_o}, {31'd0, claimed && k == nph - 1});
      if (claimed && rd) begin
        chk(ad_oe === 1'b1, "R6 output enable on read", {31'd0, ad_oe}, 32'd1);
        chk(ad_out === model[idx], rtag, ad_out, model[idx]);
      end else begin
        chk(ad_oe === 1'b0 && ad_out === '0, "R6 quiet when not reading", ad_out, 32'd0);
      end
      if (claimed && !rd) model[idx] = merge(model[idx], wd, be);
      idx = idx + 1'b1;
    end
    if (idle_after || !claimed) begin
      @(negedge clk);
      frame_n = 1'b1; irdy_n = 1'b1; ad_in = $urandom; cbe_n = 4'hF;
      #1 chk(devsel_n === 1'b1 && trdy_n === 1'b1 && ad_oe === 1'b0,
             "R8 strobes released after final", {30'd0, devsel_n, trdy_n}, 32'd3);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    #1 chk(trdy_n === 1'b1 && devsel_n === 1'b1 && ad_oe === 1'b0 && last_o === 1'b0,
           "R1 outputs in reset", {28'd0, trdy_n, devsel_n, ad_oe, last_o}, 32'hC);
    @(negedge clk); rst_n = 1'b1;
    // R1: every register reads zero after reset
    txn(BASE, RD, 16, 0, 1, -1, "R1 register zero after reset");
    // R5: full-lane burst fill, then read back (R7 increments)
    txn(BASE, WR, 16, 0, 1, 0, "R5");
    txn(BASE, RD, 16, 1, 1, -1, "R7 burst read after full fill");
    // R5: no lanes enabled, then alternating lanes
    txn(BASE + 8, WR, 1, 0, 1, 4'b1111, "R5");
    txn(BASE + 8, RD, 1, 0, 1, -1, "R5 no-lane write keeps word");
    txn(BASE + 36, WR, 1, 0, 1, 4'b1010, "R5");
    txn(BASE + 36, RD, 1, 0, 1, -1, "R5 partial lanes merged");
    // R7: wrap from register 15 to 0
    txn(BASE + 56, WR, 4, 1, 1, 0, "R7");
    txn(BASE + 60, RD, 3, 0, 1, -1, "R7 index wraps to zero");
    // R3: foreign command in window, memory write past the window
    txn(BASE + 4, 4'b0011, 2, 0, 1, 0, "R3");
    txn(BASE + 64, WR, 2, 0, 1, 0, "R3");
    txn(BASE + 2, WR, 1, 0, 1, 0, "R3");
    txn(BASE, RD, 3, 0, 1, -1, "R3 ignored writes left registers");
    // R8: back-to-back without idle
    txn(BASE + 20, RD, 2, 0, 0, -1, "R8 back-to-back read");
    txn(BASE + 24, WR, 2, 1, 0, -1, "R8");
    txn(BASE + 20, RD, 3, 0, 1, -1, "R8 read after back-to-back");
    // random mix
    for (int t = 0; t < 300; t++) begin
      logic [31:0] a;
      logic [3:0]  c;
      int sel = int'($urandom % 10);
      c = (sel < 4) ? RD : (sel < 8) ? WR : 4'($urandom);
      a = ($urandom % 5 != 0) ? BASE + 32'(($urandom % 16) * 4) : $urandom;
      txn(a, c, 1 + int'($urandom % 5), 1, $urandom % 2 == 0, -1, "R6 random read data");
    end
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b1;
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule